// File: doc/BRIEF.md
# Remote-Only Module-Side Cache

This block is a cache level shared by every processor of one compute module. It sits between the processors' private first-level caches and the module crossbar. Its purpose is to cut traffic on the links between modules. It keeps lines only for addresses whose home memory partition lies on another module. Any access to the module's own partition goes straight to the crossbar and leaves the cache state alone.

Writes are always forwarded downstream (write-through), so the cache never holds dirty data and software-managed coherence stays valid. At a synchronization point each processor sends an invalidate tagged with an epoch number. The block merges all invalidates that carry the same epoch into one flash clear of every valid bit. The cache is set-associative with true LRU replacement. It serves one request at a time: a remote read miss fetches one full 128-byte line and blocks new requests until that fill returns.

Top module: `rmt_cache`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and ds_valid are low, and the cache is empty: the first remote read misses.
- R2: A remote read miss issues exactly one downstream read with ds_fill=1 and ds_write=0, at the line-aligned address (byte-offset bits [6:0] zero). It returns the addressed 32-bit word, taken from bits [32*w+31:32*w] of the returned line, where w = addr[6:2]. A later read of any word in that line hits and makes no downstream request.
- R3: A local request (req_remote=0) is forwarded at its exact address with ds_fill=0 and never allocates, so repeating a local read goes downstream again.
- R4: Every write, local or remote, hit or miss, is forwarded downstream with ds_write=1 and its address and data.
- R5: A remote write that hits updates the cached word, and a later read returns the new data without a downstream request.
- R6: A write miss does not allocate, so a later read of that line misses.
- R7: Once a request is accepted, req_ready stays low until its one-cycle rsp_valid pulse. Writes also answer with rsp_valid once the downstream write is accepted.
- R8: Replacement within a set evicts the least recently used way, where both hits and fills count as uses.
- R9: An invalidate carrying an epoch that differs from the last recorded epoch clears every line. req_ready is low for exactly that one flush cycle, and the new epoch is recorded.
- R10: Invalidates that repeat the recorded epoch, whether in the same cycle from several processors or later, cause no further flush.
- R11: The recorded epoch resets to 0, so an epoch-0 invalidate after reset has no effect.
- R12: An invalidate that arrives while a request is in progress is held until that request has completed, and only then is the flush performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | WORD_W | Write data |
| req_remote | input | 1 | 1 = home partition is on another module |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read data |
| ds_valid | output | 1 | Downstream request present |
| ds_ready | input | 1 | Crossbar accepts the downstream request |
| ds_addr | output | ADDR_W | Downstream address |
| ds_write | output | 1 | Downstream write |
| ds_wdata | output | WORD_W | Downstream write data |
| ds_fill | output | 1 | Downstream read is a line fill for this cache |
| dsr_valid | input | 1 | Downstream read data present |
| dsr_data | input | LINE_BYTES*8 | Line containing the requested address |
| inv_valid | input | N_PROC | Per-processor invalidate strobe |
| inv_epoch | input | N_PROC*EPOCH_W | Per-processor epoch, processor i at bits [i*EPOCH_W +: EPOCH_W] |

## Verification
The bench aims at stale-data cases that a wrong design would expose only later. It changes the backing memory behind the cache and then checks whether a read returns the cached copy or the fresh one. This shows a lost flush, a double flush for a repeated epoch, a flush wrongly taken for epoch 0, and a flush run during an outstanding fill that then installs a line which should be gone. LRU is checked by filling all four ways of one set, touching the oldest way and then forcing two evictions. A design that ignored hits in its ordering would evict the touched line, and that line would then miss. Local reads issued twice, and write misses followed by reads, show any allocation that should not happen through the downstream request count.

// File: rtl/rmt_cache_pkg.sv
package rmt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DSREQ,
    ST_FILL
  } rc_state_e;
endpackage

// File: rtl/rmt_tag_lru.sv
module rmt_tag_lru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] vic_way_o,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             flush_i
);
  logic [WAYS-1:0]  vld  [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAY_W-1:0] age  [SETS][WAYS];

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[set_i][w] && tags[set_i][w] == tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

  // Victim: lowest invalid way, otherwise the oldest way
  always_comb begin
    logic found;
    found     = 1'b0;
    vic_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[set_i][w]) begin
        vic_way_o = WAY_W'(w);
        found     = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age[set_i][w] == WAY_W'(WAYS - 1)) vic_way_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) age[s][w] <= WAY_W'(w);
      end
    end else begin
      if (flush_i) begin
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end
      if (fill_i) begin
        tags[set_i][fill_way_i] <= tag_i;
        vld[set_i][fill_way_i]  <= 1'b1;
      end
      if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i)
            age[set_i][w] <= '0;
          else if (age[set_i][w] < age[set_i][touch_way_i])
            age[set_i][w] <= age[set_i][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rmt_line_ram.sv
module rmt_line_ram #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int LINE_W = 1024,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic [SET_W-1:0]             rd_set_i,
  output logic [WAYS-1:0][LINE_W-1:0]  rd_line_o,
  input  logic                         wr_en_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [SET_W-1:0]             wr_set_i,
  input  logic [LINE_W-1:0]            wr_line_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_way_i == WAY_W'(w)) mem[wr_set_i] <= wr_line_i;
      rd_line_o[w] <= mem[rd_set_i];
    end
  end
endmodule

// File: rtl/rmt_epoch_merge.sv
module rmt_epoch_merge #(
  parameter int N_SRC   = 4,
  parameter int EPOCH_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         inv_valid_i,
  input  logic [N_SRC*EPOCH_W-1:0] inv_epoch_i,
  input  logic                     flush_ack_i,
  output logic                     flush_pend_o
);
  logic [EPOCH_W-1:0] last_q;
  logic [EPOCH_W-1:0] sel;
  logic               fresh;

  // Lowest-index strobe with an epoch different from the recorded one wins
  always_comb begin
    fresh = 1'b0;
    sel   = last_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (!fresh && inv_valid_i[i] && inv_epoch_i[i*EPOCH_W +: EPOCH_W] != last_q) begin
        fresh = 1'b1;
        sel   = inv_epoch_i[i*EPOCH_W +: EPOCH_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q       <= '0;
      flush_pend_o <= 1'b0;
    end else begin
      if (flush_ack_i) flush_pend_o <= 1'b0;
      if (fresh) begin
        last_q       <= sel;
        flush_pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmt_cache.sv
module rmt_cache
  import rmt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int N_PROC     = 4,
  parameter int EPOCH_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic [WORD_W-1:0]         req_wdata,
  input  logic                      req_remote,
  output logic                      rsp_valid,
  output logic [WORD_W-1:0]         rsp_rdata,
  output logic                      ds_valid,
  input  logic                      ds_ready,
  output logic [ADDR_W-1:0]         ds_addr,
  output logic                      ds_write,
  output logic [WORD_W-1:0]         ds_wdata,
  output logic                      ds_fill,
  input  logic                      dsr_valid,
  input  logic [LINE_BYTES*8-1:0]   dsr_data,
  input  logic [N_PROC-1:0]         inv_valid,
  input  logic [N_PROC*EPOCH_W-1:0] inv_epoch
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WB_W   = $clog2(WORD_W / 8);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = $clog2(WAYS);

  rc_state_e             state;
  logic [ADDR_W-1:0]     q_addr;
  logic                  q_write;
  logic [WORD_W-1:0]     q_wdata;
  logic                  q_remote;

  logic                  flush_pend;
  logic                  flush_go;
  logic                  accept;
  logic                  lk_hit;
  logic [WAY_W-1:0]      hit_way;
  logic [WAY_W-1:0]      vic_way;
  logic [WAYS-1:0][LINE_W-1:0] rd_lines;
  logic [SET_W-1:0]      rd_set;
  logic [SET_W-1:0]      q_set;
  logic [TAG_W-1:0]      q_tag;
  logic [WIDX_W-1:0]     q_widx;
  logic [LINE_W-1:0]     hit_line;
  logic [LINE_W-1:0]     merged_line;
  logic [WORD_W-1:0]     hit_word;
  logic [WORD_W-1:0]     fill_word;
  logic                  rhit;
  logic                  fill_now;
  logic                  wr_en;
  logic [WAY_W-1:0]      wr_way;
  logic [LINE_W-1:0]     wr_line;

  assign q_set   = q_addr[OFF_W +: SET_W];
  assign q_tag   = q_addr[ADDR_W-1 -: TAG_W];
  assign q_widx  = q_addr[WB_W +: WIDX_W];
  assign rd_set  = (state == ST_IDLE) ? req_addr[OFF_W +: SET_W] : q_set;

  assign req_ready = (state == ST_IDLE) && !flush_pend;
  assign accept    = req_valid && req_ready;
  assign flush_go  = (state == ST_IDLE) && flush_pend;

  assign rhit      = (state == ST_LOOK) && q_remote && lk_hit;
  assign fill_now  = (state == ST_FILL) && dsr_valid && q_remote && !q_write;

  assign hit_line  = rd_lines[hit_way];
  assign hit_word  = hit_line[q_widx*WORD_W +: WORD_W];
  assign fill_word = dsr_data[q_widx*WORD_W +: WORD_W];

  always_comb begin
    merged_line = hit_line;
    merged_line[q_widx*WORD_W +: WORD_W] = q_wdata;
  end

  assign wr_en   = (rhit && q_write) || fill_now;
  assign wr_way  = (state == ST_LOOK) ? hit_way : vic_way;
  assign wr_line = (state == ST_LOOK) ? merged_line : dsr_data;

  rmt_epoch_merge #(.N_SRC(N_PROC), .EPOCH_W(EPOCH_W)) u_merge (
    .clk(clk), .rst(rst), .inv_valid_i(inv_valid), .inv_epoch_i(inv_epoch),
    .flush_ack_i(flush_go), .flush_pend_o(flush_pend)
  );

  rmt_tag_lru #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .set_i(q_set), .tag_i(q_tag),
    .hit_o(lk_hit), .hit_way_o(hit_way), .vic_way_o(vic_way),
    .touch_i(rhit || fill_now), .touch_way_i(wr_way),
    .fill_i(fill_now), .fill_way_i(vic_way), .flush_i(flush_go)
  );

  rmt_line_ram #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_set_i(rd_set), .rd_line_o(rd_lines),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_set_i(q_set), .wr_line_i(wr_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      q_addr    <= '0;
      q_write   <= 1'b0;
      q_wdata   <= '0;
      q_remote  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ds_valid  <= 1'b0;
      ds_addr   <= '0;
      ds_write  <= 1'b0;
      ds_wdata  <= '0;
      ds_fill   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            q_addr   <= req_addr;
            q_write  <= req_write;
            q_wdata  <= req_wdata;
            q_remote <= req_remote;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (rhit && !q_write) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= hit_word;
            state     <= ST_IDLE;
          end else begin
            ds_valid <= 1'b1;
            ds_write <= q_write;
            ds_wdata <= q_wdata;
            ds_fill  <= q_remote && !q_write;
            ds_addr  <= (q_remote && !q_write) ? {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : q_addr;
            state    <= ST_DSREQ;
          end
        end
        ST_DSREQ: begin
          if (ds_ready) begin
            ds_valid <= 1'b0;
            if (q_write) begin
              rsp_valid <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (dsr_valid) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= fill_word;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmt_cache_chk.sv
module rmt_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ds_valid,
  input logic              ds_ready,
  input logic [ADDR_W-1:0] ds_addr,
  input logic              ds_write,
  input logic              ds_fill
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R7
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> !req_ready);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  ds_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_addr) && $stable(ds_write)));

  // R2
  fill_align_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_valid && ds_fill) |-> (ds_addr[OFF_W-1:0] == '0 && !ds_write));
endmodule

bind rmt_cache rmt_cache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ds_valid(ds_valid), .ds_ready(ds_ready),
  .ds_addr(ds_addr), .ds_write(ds_write), .ds_fill(ds_fill)
);

// File: tb/rmt_cache_tb_top.sv
module rmt_cache_tb_top;
  localparam int ADDR_W = 32, WORD_W = 32, LINE_BYTES = 128, LINE_W = 1024;
  localparam int N_PROC = 4, EPOCH_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_remote = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ds_valid, ds_write, ds_fill;
  logic [WORD_W-1:0] rsp_rdata, ds_wdata;
  logic [ADDR_W-1:0] ds_addr;
  logic ds_ready = 1'b0, dsr_valid = 1'b0;
  logic [LINE_W-1:0] dsr_data = '0;
  logic [N_PROC-1:0] inv_valid = '0;
  logic [N_PROC*EPOCH_W-1:0] inv_epoch = '0;

  int checks = 0, errors = 0;
  int ds_cnt = 0;
  logic [31:0] last_ds_addr;
  logic last_ds_fill, last_ds_write;
  logic [31:0] mem_m [logic [31:0]];

  always #10 clk = ~clk;

  rmt_cache dut_i (.*);

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (mem_m.exists(k)) return mem_m[k];
    return {k[15:0] ^ 16'h5a5a, k[31:16] ^ k[15:0]};
  endfunction

  function automatic logic [LINE_W-1:0] mk_line(input logic [31:0] a);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < LINE_W / 32; i++) l[i*32 +: 32] = mem_rd({a[31:7], 7'b0} + 32'(i * 4));
    return l;
  endfunction

  function automatic logic [31:0] mk_addr(input int tag, input int set, input int word);
    return 32'((tag << 11) | (set << 7) | (word << 2));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Downstream crossbar model
  initial begin
    logic pend;
    int dly;
    logic [31:0] raddr;
    pend = 1'b0; dly = 0; raddr = '0;
    forever begin
      @(negedge clk);
      dsr_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          dsr_valid = 1'b1;
          dsr_data  = mk_line(raddr);
          pend      = 1'b0;
        end else dly--;
      end
      ds_ready = ($urandom % 3) != 0;
      if (!rst && ds_valid && ds_ready) begin
        ds_cnt++;
        last_ds_addr  = ds_addr;
        last_ds_fill  = ds_fill;
        last_ds_write = ds_write;
        if (ds_write) mem_m[{ds_addr[31:2], 2'b00}] = ds_wdata;
        else begin
          pend  = 1'b1;
          dly   = int'($urandom % 3);
          raddr = ds_addr;
        end
      end
    end
  end

  task automatic op(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                    input logic rm, output logic [31:0] rd);
    int t;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_remote = rm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) chk(req_ready == 1'b0, "R7 ready low while busy", 32'(req_ready), 32'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (t >= 200) chk(1'b0, "R7 response timeout", 32'(t), 32'd200);
    rd = rsp_rdata;
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic rm, input int exp_ds,
                        input logic [31:0] exp, input string req);
    int c0;
    logic [31:0] r;
    c0 = ds_cnt;
    op(a, 1'b0, '0, rm, r);
    chk(r == exp, req, r, exp);
    chk(ds_cnt - c0 == exp_ds, req, 32'(ds_cnt - c0), 32'(exp_ds));
  endtask

  task automatic pulse_inv(input logic [N_PROC-1:0] m, input int ep);
    @(negedge clk);
    inv_valid = m;
    for (int i = 0; i < N_PROC; i++) inv_epoch[i*EPOCH_W +: EPOCH_W] = EPOCH_W'(ep);
    @(negedge clk);
    inv_valid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] a, b, c, d, r, wd, old;
    int c0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0 && ds_valid == 1'b0, "R1 idle outputs", 32'({rsp_valid, ds_valid}), 32'd0);

    // R1/R2 first remote read misses, fills aligned line
    a = mk_addr('h201, 3, 5);
    rd_chk(a, 1'b1, 1, mem_rd(a), "R1 R2 remote miss");
    chk(last_ds_fill == 1'b1 && last_ds_write == 1'b0, "R2 fill flag", 32'({last_ds_fill, last_ds_write}), 32'h2);
    chk(last_ds_addr == {a[31:7], 7'b0}, "R2 aligned address", last_ds_addr, {a[31:7], 7'b0});
    rd_chk(mk_addr('h201, 3, 9), 1'b1, 0, mem_rd(mk_addr('h201, 3, 9)), "R2 hit other word");

    // R3 local reads pass through every time
    b = mk_addr('h011, 3, 2);
    rd_chk(b, 1'b0, 1, mem_rd(b), "R3 local read");
    chk(last_ds_addr == b && last_ds_fill == 1'b0, "R3 exact address", last_ds_addr, b);
    rd_chk(b, 1'b0, 1, mem_rd(b), "R3 local read again");

    // R4/R5 remote write hit
    wd = 32'hCAFE_0001;
    c0 = ds_cnt;
    op(a, 1'b1, wd, 1'b1, r);
    chk(ds_cnt - c0 == 1 && last_ds_write == 1'b1 && last_ds_addr == a, "R4 write forwarded", last_ds_addr, a);
    chk(mem_rd(a) == wd, "R4 write data", mem_rd(a), wd);
    rd_chk(a, 1'b1, 0, wd, "R5 write hit updates line");

    // R4/R6 remote write miss, no allocation
    c = mk_addr('h202, 3, 0);
    wd = 32'hBEEF_0002;
    op(c, 1'b1, wd, 1'b1, r);
    chk(mem_rd(c) == wd, "R4 write miss forwarded", mem_rd(c), wd);
    rd_chk(c, 1'b1, 1, wd, "R6 write miss no allocate");

    // R8 LRU in set 6
    for (int t = 0; t < 4; t++) rd_chk(mk_addr('h210 + t, 6, 0), 1'b1, 1, mem_rd(mk_addr('h210 + t, 6, 0)), "R8 fill ways");
    rd_chk(mk_addr('h210, 6, 1), 1'b1, 0, mem_rd(mk_addr('h210, 6, 1)), "R8 touch oldest");
    rd_chk(mk_addr('h214, 6, 0), 1'b1, 1, mem_rd(mk_addr('h214, 6, 0)), "R8 evict");
    rd_chk(mk_addr('h210, 6, 0), 1'b1, 0, mem_rd(mk_addr('h210, 6, 0)), "R8 touched line kept");
    rd_chk(mk_addr('h211, 6, 0), 1'b1, 1, mem_rd(mk_addr('h211, 6, 0)), "R8 LRU line evicted");
    rd_chk(mk_addr('h213, 6, 0), 1'b1, 0, mem_rd(mk_addr('h213, 6, 0)), "R8 second eviction picks LRU");

    // R11 epoch 0 ignored after reset
    old = mem_rd(a);
    pulse_inv(4'b0001, 0);
    chk(req_ready == 1'b1, "R11 no flush cycle", 32'(req_ready), 32'd1);
    mem_m[{a[31:2], 2'b00}] = 32'h1111_2222;
    rd_chk(a, 1'b1, 0, old, "R11 line still cached");

    // R9 new epoch flushes, one ready-low cycle
    pulse_inv(4'b0010, 3);
    chk(req_ready == 1'b0, "R9 flush cycle", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 single flush cycle", 32'(req_ready), 32'd1);
    rd_chk(a, 1'b1, 1, 32'h1111_2222, "R9 line cleared");

    // R10 merged invalidates, one flush, repeat epoch ignored
    pulse_inv(4'b1111, 5);
    chk(req_ready == 1'b0, "R10 flush once", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 no second flush", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 no second flush later", 32'(req_ready), 32'd1);
    c = mk_addr('h220, 9, 4);
    old = mem_rd(c);
    rd_chk(c, 1'b1, 1, old, "R10 fill after flush");
    pulse_inv(4'b0100, 5);
    chk(req_ready == 1'b1, "R10 repeat epoch ignored", 32'(req_ready), 32'd1);
    mem_m[{c[31:2], 2'b00}] = 32'h3333_4444;
    rd_chk(c, 1'b1, 0, old, "R10 line survives repeat");

    // R12 flush deferred past an outstanding fill
    d = mk_addr('h230, 12, 7);
    fork
      op(d, 1'b0, '0, 1'b1, r);
      begin
        repeat (2) @(negedge clk);
        inv_valid = 4'b1000;
        inv_epoch[3*EPOCH_W +: EPOCH_W] = 4'd7;
        @(negedge clk);
        inv_valid = '0;
      end
    join
    chk(r == mem_rd(d), "R12 fill data", r, mem_rd(d));
    mem_m[{d[31:2], 2'b00}] = 32'h5555_6666;
    rd_chk(d, 1'b1, 1, 32'h5555_6666, "R12 flush after fill");

    // Random mix over sets 0 and 1
    pulse_inv(4'b0001, 9);
    for (int n = 0; n < 300; n++) begin
      int tg;
      logic rm, wr;
      tg = ($urandom % 2) ? int'('h201 + $urandom % 5) : int'('h011 + $urandom % 2);
      rm = (tg & 'h200) != 0;
      a  = mk_addr(tg, int'($urandom % 2), int'($urandom % 32));
      wr = ($urandom % 10) < 3;
      wd = $urandom;
      op(a, wr, wd, rm, r);
      if (wr) chk(mem_rd(a) == wd, rm ? "R4 random remote write" : "R4 random local write", mem_rd(a), wd);
      else chk(r == mem_rd(a), rm ? "R2 R5 random remote read" : "R3 random local read", r, mem_rd(a));
    end
    finish_run();
  end
endmodule